// File: doc/BRIEF.md
# Video Crop Window Selector

This block sits in a pixel stream that is qualified by line-start and frame-start events, and passes only one rectangular sub-window of each frame. Everything else is dropped. The window is described by its upper-left corner and its size. The horizontal offset and the width are counted in valid pixel-clock beats since the last line start. The vertical start and the height are counted in lines since the last frame start.

Two 32-bit configuration words carry the settings. The origin word holds the horizontal offset and the first line. The extent word holds the capture count and the line count. Both words are sampled only in the cycle that carries a frame start, so each frame is cut with one consistent window.

Accepted beats come out one clock later with their data unchanged. The last beat of every windowed line carries a line-end marker. The last beat of the last windowed line also carries a frame-end marker. The window is assumed to lie inside the incoming frame.

Top module: `crop_window_top`

## Requirements
- R1: While reset is high, and after reset until the first frame start, `out_valid`, `out_line_end` and `out_frame_end` are low, and no beat is passed.
- R2: In the origin word, bits [13:0] give the horizontal offset and bits [28:16] give the first line. In the extent word, bits [13:0] give the capture count and bits [29:16] give the line count. All other bits have no effect.
- R3: A beat's horizontal position is the number of earlier valid beats since the last line start. A valid beat in the same cycle as `line_start` has position 0. Beats whose position is below the offset are dropped.
- R4: A capture count of N passes exactly the positions offset .. offset+N on each windowed line, which is N+1 beats. Later beats on that line are dropped.
- R5: Line index 0 is the first line start at or after a frame start, including one in the same cycle. A line count of M passes lines first .. first+M, which is M+1 lines. Other lines are dropped, and so are valid beats between a frame start and the next line start.
- R6: An accepted beat appears on `out_valid`/`out_data` exactly one clock after it was presented, with its data unchanged.
- R7: `out_line_end` is high together with the beat at position offset+N of every windowed line, and at no other time.
- R8: `out_frame_end` is high together with the line-end beat of line first+M, and at no other time.
- R9: The configuration words are sampled only in a cycle with `frame_start` high. Changes at any other time have no effect on the frame in progress.
- R10: Cycles with `in_valid` low do not advance the horizontal position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_origin | input | 32 | Horizontal offset and first line |
| cfg_extent | input | 32 | Capture count and line count |
| in_valid | input | 1 | Input pixel beat strobe |
| in_data | input | DATA_W | Input pixel data |
| line_start | input | 1 | Start-of-line event (single cycle) |
| frame_start | input | 1 | Start-of-frame event (single cycle) |
| out_valid | output | 1 | Windowed beat strobe |
| out_data | output | DATA_W | Windowed pixel data |
| out_line_end | output | 1 | Last beat of a windowed line |
| out_frame_end | output | 1 | Last beat of the window in this frame |

## Verification
The assertions assume that `line_start` and `frame_start` are single-cycle events. They also assume the configured window fits inside the frame that is actually delivered, so every windowed line reaches its last position.

The stimulus always opens a line with a valid beat that coincides with `line_start`. It sizes each frame so that the window ends inside it, and it keeps the configuration words at a different window in every cycle except the frame-start cycle. Idle gaps inside lines, and frames that open with a frame start on its own, exercise the counting rules without ever leaving those assumptions.

// File: rtl/crop_pkg.sv
package crop_pkg;

    localparam int HOFF_W = 14;
    localparam int HCNT_W = 14;
    localparam int VST_W  = 13;
    localparam int VCNT_W = 14;
    localparam int CNT_W  = 15;

    localparam int HOFF_LSB = 0;
    localparam int VST_LSB  = 16;
    localparam int HCNT_LSB = 0;
    localparam int VCNT_LSB = 16;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [HOFF_W-1:0] hoff;
        logic [VST_W-1:0]  vst;
        logic [HCNT_W-1:0] hcnt;
        logic [VCNT_W-1:0] vcnt;
    } crop_win_t;

    typedef struct packed {
        logic [CNT_W-1:0] h_first;
        logic [CNT_W-1:0] h_last;
        logic [CNT_W-1:0] v_first;
        logic [CNT_W-1:0] v_last;
    } crop_bounds_t;

    typedef struct packed {
        logic             live;
        logic [CNT_W-1:0] idx;
    } crop_line_t;

    function automatic crop_bounds_t win_bounds(crop_win_t w);
        crop_bounds_t b;
        b.h_first = CNT_W'(w.hoff);
        b.h_last  = CNT_W'(w.hoff) + CNT_W'(w.hcnt);
        b.v_first = CNT_W'(w.vst);
        b.v_last  = CNT_W'(w.vst) + CNT_W'(w.vcnt);
        return b;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + CNT_W'(1);
    endfunction

endpackage

// File: rtl/crop_cfg_shadow.sv
module crop_cfg_shadow
    import crop_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_start,
    input  logic [31:0]  cfg_origin,
    input  logic [31:0]  cfg_extent,
    output crop_bounds_t eff_bounds,
    output logic         eff_framed
);
    crop_win_t    word_win;
    crop_bounds_t word_bounds;
    crop_bounds_t held_q;
    logic         framed_q;
    logic         cfg_unused;

    always_comb begin
        word_win.hoff = cfg_origin[HOFF_LSB +: HOFF_W];
        word_win.vst  = cfg_origin[VST_LSB  +: VST_W];
        word_win.hcnt = cfg_extent[HCNT_LSB +: HCNT_W];
        word_win.vcnt = cfg_extent[VCNT_LSB +: VCNT_W];
        word_bounds   = win_bounds(word_win);
    end

    assign cfg_unused = ^{cfg_origin[31:VST_LSB+VST_W], cfg_origin[VST_LSB-1:HOFF_W],
                          cfg_extent[31:VCNT_LSB+VCNT_W], cfg_extent[VCNT_LSB-1:HCNT_W]};

    // The frame-start cycle already uses the new setting.
    assign eff_bounds = frame_start ? word_bounds : held_q;
    assign eff_framed = frame_start | framed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            framed_q <= 1'b0;
        end else if (frame_start) begin
            held_q   <= word_bounds;
            framed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/crop_line_track.sv
module crop_line_track
    import crop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       line_start,
    output crop_line_t eff_line
);
    logic [CNT_W-1:0] idx_q;
    logic             live_q;
    logic             fresh_q;

    always_comb begin
        if (line_start) begin
            eff_line.live = 1'b1;
            eff_line.idx  = (frame_start || fresh_q) ? '0 : sat_inc(idx_q);
        end else if (frame_start) begin
            eff_line.live = 1'b0;
            eff_line.idx  = idx_q;
        end else begin
            eff_line.live = live_q;
            eff_line.idx  = idx_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            live_q  <= 1'b0;
            fresh_q <= 1'b1;
        end else begin
            idx_q  <= eff_line.idx;
            live_q <= eff_line.live;
            if (line_start)
                fresh_q <= 1'b0;
            else if (frame_start)
                fresh_q <= 1'b1;
        end
    end
endmodule

// File: rtl/crop_pixel_track.sv
module crop_pixel_track
    import crop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             in_valid,
    output logic [CNT_W-1:0] eff_pos
);
    logic [CNT_W-1:0] pos_q;

    assign eff_pos = line_start ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (in_valid)
            pos_q <= sat_inc(eff_pos);
        else
            pos_q <= eff_pos;
    end
endmodule

// File: rtl/crop_window_gate.sv
module crop_window_gate
    import crop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  crop_bounds_t      bounds,
    input  logic              framed,
    input  crop_line_t        line,
    input  logic [CNT_W-1:0]  pix_pos,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_line_end,
    output logic              out_frame_end
);
    localparam int AXES = 2;

    logic [CNT_W-1:0] ax_pos   [AXES];
    logic [CNT_W-1:0] ax_first [AXES];
    logic [CNT_W-1:0] ax_last  [AXES];
    logic [AXES-1:0]  ax_in;
    logic [AXES-1:0]  ax_end;
    logic             take;

    assign ax_pos[0]   = pix_pos;
    assign ax_first[0] = bounds.h_first;
    assign ax_last[0]  = bounds.h_last;
    assign ax_pos[1]   = line.idx;
    assign ax_first[1] = bounds.v_first;
    assign ax_last[1]  = bounds.v_last;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        assign ax_in[a]  = (ax_pos[a] >= ax_first[a]) && (ax_pos[a] <= ax_last[a]);
        assign ax_end[a] = (ax_pos[a] == ax_last[a]);
    end

    assign take = in_valid && framed && line.live && (&ax_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_line_end  <= 1'b0;
            out_frame_end <= 1'b0;
        end else begin
            out_valid     <= take;
            out_line_end  <= take && ax_end[0];
            out_frame_end <= take && ax_end[0] && ax_end[1];
            if (take)
                out_data <= in_data;
        end
    end
endmodule

// File: rtl/crop_window_top.sv
module crop_window_top
    import crop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cfg_origin,
    input  logic [31:0]       cfg_extent,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              line_start,
    input  logic              frame_start,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_line_end,
    output logic              out_frame_end
);
    crop_bounds_t     bounds;
    logic             framed;
    crop_line_t       line;
    logic [CNT_W-1:0] pix_pos;

    crop_cfg_shadow u_cfg (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cfg_origin(cfg_origin), .cfg_extent(cfg_extent),
        .eff_bounds(bounds), .eff_framed(framed)
    );

    crop_line_track u_line (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .line_start(line_start), .eff_line(line)
    );

    crop_pixel_track u_pix (
        .clk(clk), .rst(rst), .line_start(line_start),
        .in_valid(in_valid), .eff_pos(pix_pos)
    );

    crop_window_gate #(.DATA_W(DATA_W)) u_gate (
        .clk(clk), .rst(rst), .bounds(bounds), .framed(framed),
        .line(line), .pix_pos(pix_pos), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_line_end(out_line_end), .out_frame_end(out_frame_end)
    );
endmodule

// File: rtl/crop_window_chk.sv
module crop_window_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              frame_start,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_line_end,
    input logic              out_frame_end
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (frame_start) seen_q <= 1'b1;
    end

    assert_quiet_before_frame_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> seen_q);

    assert_beat_follows_input_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_data_unchanged_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == $past(in_data)));

    assert_line_end_on_beat_R7: assert property (@(posedge clk) disable iff (rst)
        out_line_end |-> out_valid);

    assert_frame_end_on_line_end_R8: assert property (@(posedge clk) disable iff (rst)
        out_frame_end |-> out_line_end);
endmodule

bind crop_window_top crop_window_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .frame_start(frame_start), .out_valid(out_valid), .out_data(out_data),
    .out_line_end(out_line_end), .out_frame_end(out_frame_end)
);

// File: tb/crop_window_top_tb.sv
`timescale 1ns/1ps
module crop_window_top_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   cfg_origin = '0;
    logic [31:0]   cfg_extent = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          line_start = 1'b0;
    logic          frame_start = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_line_end;
    logic          out_frame_end;

    always #2.5 clk = ~clk;

    crop_window_top #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .cfg_origin(cfg_origin), .cfg_extent(cfg_extent),
        .in_valid(in_valid), .in_data(in_data), .line_start(line_start),
        .frame_start(frame_start), .out_valid(out_valid), .out_data(out_data),
        .out_line_end(out_line_end), .out_frame_end(out_frame_end)
    );

    typedef struct packed {
        logic [DW-1:0] d;
        logic          le;
        logic          fe;
    } exp_t;

    exp_t    q[$];
    int      n_cmp = 0, n_bad = 0;
    int      obs_cnt = 0, obs_le = 0, obs_fe = 0;
    int      exp_cnt, exp_le, exp_fe;
    logic [DW-1:0] pix = '0;
    logic [31:0] junk_o, junk_e;

    task automatic chk(bit ok, string tag, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // R2: origin = {junk, first line [28:16], junk, offset [13:0]}
    function automatic logic [31:0] pack_origin(int h, int v);
        return {3'b101, 13'(v), 2'b11, 14'(h)};
    endfunction
    // R2: extent = {junk, line count [29:16], junk, capture count [13:0]}
    function automatic logic [31:0] pack_extent(int hc, int vc);
        return {2'b11, 14'(vc), 2'b10, 14'(hc)};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            obs_cnt++;
            if (out_line_end) obs_le++;
            if (out_frame_end) obs_fe++;
            if (q.size() == 0) begin
                chk(1'b0, "R1/R5 unexpected beat", out_data, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(out_data == e.d, "R6 data", out_data, e.d);
                chk(out_line_end == e.le, "R7 line end", out_line_end, e.le);
                chk(out_frame_end == e.fe, "R8 frame end", out_frame_end, e.fe);
            end
        end
    end

    task automatic drive(bit v, bit ls, bit fs);
        @(posedge clk); #1;
        in_valid = v; line_start = ls; frame_start = fs; in_data = pix;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0);
        cfg_origin = junk_o; cfg_extent = junk_e;
    endtask

    task automatic expect_beat(int l, int p, int hoff, int hcnt, int vst, int vcnt);
        if (p >= hoff && p <= hoff + hcnt && l >= vst && l <= vst + vcnt) begin
            exp_t e;
            e.d  = pix;
            e.le = (p == hoff + hcnt);
            e.fe = (p == hoff + hcnt) && (l == vst + vcnt);
            q.push_back(e);
            exp_cnt++;
            if (e.le) exp_le++;
            if (e.fe) exp_fe++;
        end
    endtask

    task automatic run_frame(string tag, int hoff, int hcnt, int vst, int vcnt,
                             int nl, int np, bit fs_ls, bit gaps);
        exp_cnt = 0; exp_le = 0; exp_fe = 0;
        obs_cnt = 0; obs_le = 0; obs_fe = 0;
        // R9: a different window sits on the words outside the frame-start cycle
        junk_o = pack_origin(0, 0);
        junk_e = pack_extent(200, 200);
        idle();
        if (!fs_ls) begin
            // frame start alone, with a stray beat that belongs to no line (R5)
            drive(1'b1, 1'b0, 1'b1);
            cfg_origin = pack_origin(hoff, vst); cfg_extent = pack_extent(hcnt, vcnt);
            pix++;
            idle();
        end
        for (int l = 0; l < nl; l++) begin
            for (int p = 0; p < np; p++) begin
                drive(1'b1, p == 0, fs_ls && l == 0 && p == 0);
                if (fs_ls && l == 0 && p == 0) begin
                    cfg_origin = pack_origin(hoff, vst); cfg_extent = pack_extent(hcnt, vcnt);
                end else begin
                    cfg_origin = junk_o; cfg_extent = junk_e;
                end
                expect_beat(l, p, hoff, hcnt, vst, vcnt);
                pix++;
                if (gaps && (p % 3 == 1)) idle();   // R10 idle cycles inside a line
            end
            idle();
        end
        repeat (3) idle();
        chk(obs_cnt == exp_cnt, {tag, " R3/R4/R5 beat count"}, obs_cnt, exp_cnt);
        chk(obs_le == exp_le, {tag, " R7 line end count"}, obs_le, exp_le);
        chk(obs_fe == exp_fe, {tag, " R8 frame end count"}, obs_fe, exp_fe);
        chk(q.size() == 0, {tag, " R6 scoreboard drained"}, q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        junk_o = '0; junk_e = '0;
        repeat (4) @(posedge clk);
        #1;
        chk(out_valid == 0 && out_line_end == 0 && out_frame_end == 0,
            "R1 outputs in reset", {out_valid, out_line_end, out_frame_end}, 0);
        rst = 1'b0;
        // R1: lines with beats before any frame start pass nothing
        cfg_origin = pack_origin(0, 0); cfg_extent = pack_extent(50, 50);
        for (int l = 0; l < 3; l++)
            for (int p = 0; p < 6; p++) begin
                drive(1'b1, p == 0, 1'b0);
                pix++;
            end
        idle(); idle();
        chk(obs_cnt == 0, "R1 no beats before first frame", obs_cnt, 0);

        // R2/R3/R4/R5/R10: inner window, frame start alone, idle gaps
        run_frame("frameA", 2, 3, 1, 1, 5, 10, 1'b0, 1'b1);
        // R5: frame start with line start; 1x1 window at the corner
        run_frame("frameB", 0, 0, 0, 0, 3, 5, 1'b1, 1'b0);
        // R4/R5: window equal to the frame, edges exact
        run_frame("frameC", 0, 7, 0, 3, 4, 8, 1'b1, 1'b1);
        // R3/R9: window on the right and bottom edges, config churn mid-frame
        run_frame("frameD", 5, 4, 3, 2, 6, 10, 1'b0, 1'b0);
        // R9: back-to-back frame with a different setting
        run_frame("frameE", 1, 1, 2, 0, 4, 6, 1'b1, 1'b1);

        report();
        $finish;
    end
endmodule